// File: doc/BRIEF.md
# Pointer Register File with Auto-Modify

This block holds three 12-bit data pointers for an 8-bit core. Each pointer appears as a low byte and a high byte on a direct register port. Only the bottom four bits of the high byte are stored, and its top four bits read as zero. A second, indirect port receives the operand address of an instruction. When that address is one of fifteen virtual operand codes, five access modes for each of the three pointers, the block turns it into a 12-bit effective address. It also applies any post-decrement, post-increment, pre-increment or signed offset by the working register that the mode calls for.

The effective address, a suppress flag and a read-as-zero flag are combinational in the request cycle. Pointer changes take effect at the next rising clock edge. Two special cases are resolved here:

- If the effective address is itself a virtual operand code, the memory access is cancelled. A read of it returns zero.
- If an indirect write lands on a pointer half, that half takes the written byte and the accessing pointer is not auto-modified.

The data memory and the ALU sit outside the block. The block owns no status flags, so pointer arithmetic never disturbs them. The bank select and access bits are not inputs at all.

Top module: `ptr_file`

## Requirements
- R1: After a synchronous active-high reset, all three pointers hold 000h, so every pointer half reads 00h on the direct port.
- R2: The direct port places pointer n's low byte at 12'hFD8+2n and its high byte at 12'hFD9+2n. A write lands at the next rising edge. A high-byte write keeps only data bits 3:0. Reads are combinational, return 0 in bits 7:4 of a high byte, and return 00h at any other address.
- R3: Virtual operand code for pointer n (0..2) and mode m is 12'hFE0 + 8n + m, with m: 0 plain, 1 post-decrement, 2 post-increment, 3 pre-increment, 4 working-register offset. Without a request, or with a request whose operand is not such a code, eff_addr equals ind_op, suppress and rd_zero are 0, and no pointer changes.
- R4: Plain mode gives the pointer value as eff_addr and leaves the pointer unchanged.
- R5: Post-decrement and post-increment give the current pointer value as eff_addr, then the full 12-bit pointer steps by -1 or +1 modulo 4096, so a carry or borrow crosses from low byte to high byte.
- R6: Pre-increment gives pointer+1 (mod 4096) as eff_addr, and the pointer takes that same value.
- R7: Offset mode gives pointer plus the sign-extended 8-bit wreg, modulo 4096, as eff_addr. The pointer is left unchanged.
- R8: When the resulting effective address is a virtual operand code, suppress is 1. On a read, rd_zero is also 1; on a write, rd_zero is 0 and no pointer half is written. The mode's own pointer step still happens.
- R9: When an indirect write's effective address is a pointer half (R2 map), that half takes ind_wdata (bits 3:0 only for a high half), suppress is 1, and the accessing pointer gets no step.
- R10: A direct-port write to pointer n overrides every indirect change to pointer n in the same cycle. Only the directly written half changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_we | input | 1 | Direct-port write strobe |
| dir_addr | input | 12 | Direct-port register address |
| dir_wdata | input | 8 | Direct-port write byte |
| dir_rdata | output | 8 | Direct-port read byte (combinational) |
| ind_req | input | 1 | Indirect access request |
| ind_wr | input | 1 | Indirect access is a write when 1 |
| ind_op | input | 12 | Operand address of the access |
| ind_wdata | input | 8 | Byte being written by the indirect access |
| wreg | input | 8 | Working-register value for offset mode |
| eff_addr | output | 12 | Resolved effective address |
| suppress | output | 1 | Memory access must not take place |
| rd_zero | output | 1 | Read data must be forced to 00h |

## Verification
Directed patterns place pointers on byte boundaries: 0FFh and 100h for carry and borrow, and FFFh for wrap. They separate a full 12-bit step from an 8-bit one. Offsets of 80h and 7Fh distinguish sign extension from zero extension. Pointers aimed at a virtual code, or at another pointer's half, exercise the read-zero, write-drop and write-through-without-step paths. A same-cycle direct write shows which source wins. A long random run then mixes all fifteen codes, foreign operands and direct writes biased toward those same corner values, checked against a behavioural model every cycle.

// File: rtl/ptr_file_pkg.sv
package ptr_file_pkg;

    localparam int AW      = 12;   // linear data address width
    localparam int DW      = 8;    // register byte width
    localparam int NPTR    = 3;    // number of pointers
    localparam int NMODE   = 5;    // access modes per pointer
    localparam int PIW     = 2;    // pointer index width
    localparam int VSTRIDE = 8;    // spacing of virtual code groups
    localparam int HIW     = AW - DW; // stored bits of the high byte

    typedef enum logic [2:0] {
        MD_PLAIN   = 3'd0,
        MD_POSTDEC = 3'd1,
        MD_POSTINC = 3'd2,
        MD_PREINC  = 3'd3,
        MD_OFFSET  = 3'd4
    } mode_e;

    typedef struct packed {
        logic            hit;
        logic [PIW-1:0]  idx;
        mode_e           mode;
    } vop_t;

    typedef struct packed {
        logic            hit;
        logic [PIW-1:0]  idx;
        logic            hi;
    } half_t;

    typedef struct packed {
        logic [AW-1:0]   addr;
        logic [AW-1:0]   next;
        logic            upd;
    } calc_t;

    function automatic logic [AW-1:0] add_signed(input logic [AW-1:0] p,
                                                 input logic [DW-1:0] w);
        return p + {{(AW-DW){w[DW-1]}}, w};
    endfunction

    function automatic half_t decode_half(input logic [AW-1:0] a,
                                          input logic [AW-1:0] base);
        half_t r;
        r = '0;
        for (int n = 0; n < NPTR; n++) begin
            for (int h = 0; h < 2; h++) begin
                if (a == base + AW'(2*n + h)) begin
                    r.hit = 1'b1;
                    r.idx = PIW'(n);
                    r.hi  = (h == 1);
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ptr_vop_decode.sv
module ptr_vop_decode
    import ptr_file_pkg::*;
#(
    parameter logic [AW-1:0] VIRT_BASE = 12'hFE0
)(
    input  logic [AW-1:0] addr,
    output vop_t          vop
);
    logic [NPTR*NMODE-1:0] match;

    for (genvar n = 0; n < NPTR; n++) begin : g_ptr
        for (genvar m = 0; m < NMODE; m++) begin : g_mode
            localparam logic [AW-1:0] CODE = VIRT_BASE + AW'(VSTRIDE*n + m);
            assign match[n*NMODE + m] = (addr == CODE);
        end
    end

    always_comb begin
        vop = '0;
        for (int n = 0; n < NPTR; n++) begin
            for (int m = 0; m < NMODE; m++) begin
                if (match[n*NMODE + m]) begin
                    vop.hit  = 1'b1;
                    vop.idx  = PIW'(n);
                    vop.mode = mode_e'(m);
                end
            end
        end
    end
endmodule

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc
    import ptr_file_pkg::*;
(
    input  logic [AW-1:0] ptr,
    input  mode_e         mode,
    input  logic [DW-1:0] wreg,
    output calc_t         res
);
    logic [AW-1:0] inc, dec;

    assign inc = ptr + AW'(1);
    assign dec = ptr - AW'(1);

    always_comb begin
        res.addr = ptr;
        res.next = ptr;
        res.upd  = 1'b0;
        unique case (mode)
            MD_PLAIN:   ;
            MD_POSTDEC: begin res.next = dec; res.upd = 1'b1; end
            MD_POSTINC: begin res.next = inc; res.upd = 1'b1; end
            MD_PREINC:  begin res.addr = inc; res.next = inc; res.upd = 1'b1; end
            MD_OFFSET:  res.addr = add_signed(ptr, wreg);
            default:    ;
        endcase
    end
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank
    import ptr_file_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     dir_we,
    input  half_t                    dir_sel,
    input  logic [DW-1:0]            dir_wdata,
    input  logic                     iw_we,
    input  half_t                    iw_sel,
    input  logic [DW-1:0]            iw_wdata,
    input  logic                     up_en,
    input  logic [PIW-1:0]           up_idx,
    input  logic [AW-1:0]            up_val,
    output logic [NPTR-1:0][AW-1:0]  ptrs
);
    for (genvar n = 0; n < NPTR; n++) begin : g_reg
        logic [AW-1:0] q;
        logic          dir_here, iw_here, up_here;

        assign dir_here = dir_we && dir_sel.hit && (dir_sel.idx == PIW'(n));
        assign iw_here  = iw_we  && iw_sel.hit  && (iw_sel.idx  == PIW'(n));
        assign up_here  = up_en  && (up_idx == PIW'(n));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (dir_here) begin
                if (dir_sel.hi) q[AW-1:DW] <= dir_wdata[HIW-1:0];
                else            q[DW-1:0]  <= dir_wdata;
            end else if (iw_here) begin
                if (iw_sel.hi)  q[AW-1:DW] <= iw_wdata[HIW-1:0];
                else            q[DW-1:0]  <= iw_wdata;
            end else if (up_here) begin
                q <= up_val;
            end
        end

        assign ptrs[n] = q;
    end
endmodule

// File: rtl/ptr_file.sv
module ptr_file
    import ptr_file_pkg::*;
#(
    parameter logic [11:0] VIRT_BASE = 12'hFE0,
    parameter logic [11:0] PTR_BASE  = 12'hFD8
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        dir_we,
    input  logic [11:0] dir_addr,
    input  logic [7:0]  dir_wdata,
    output logic [7:0]  dir_rdata,
    input  logic        ind_req,
    input  logic        ind_wr,
    input  logic [11:0] ind_op,
    input  logic [7:0]  ind_wdata,
    input  logic [7:0]  wreg,
    output logic [11:0] eff_addr,
    output logic        suppress,
    output logic        rd_zero
);
    localparam int VIRT_END = int'(VIRT_BASE) + VSTRIDE*NPTR;

    vop_t                     src_vop, tgt_vop;
    half_t                    dir_sel, tgt_half;
    calc_t                    calc;
    logic [NPTR-1:0][AW-1:0]  ptrs;
    logic [AW-1:0]            sel_ptr;
    logic                     active, iw_we, up_en, dir_to_sel;

    ptr_vop_decode #(.VIRT_BASE(VIRT_BASE)) u_src_dec (
        .addr (ind_op),
        .vop  (src_vop)
    );

    assign sel_ptr = ptrs[src_vop.idx];

    ptr_addr_calc u_calc (
        .ptr  (sel_ptr),
        .mode (src_vop.mode),
        .wreg (wreg),
        .res  (calc)
    );

    assign active   = ind_req && src_vop.hit;
    assign eff_addr = active ? calc.addr : ind_op;

    ptr_vop_decode #(.VIRT_BASE(VIRT_BASE)) u_tgt_dec (
        .addr (calc.addr),
        .vop  (tgt_vop)
    );

    assign tgt_half = decode_half(calc.addr, PTR_BASE);
    assign dir_sel  = decode_half(dir_addr, PTR_BASE);

    assign iw_we    = active && ind_wr && tgt_half.hit && !tgt_vop.hit;
    assign up_en    = active && calc.upd && !iw_we;
    assign suppress = active && (tgt_vop.hit || iw_we);
    assign rd_zero  = active && !ind_wr && tgt_vop.hit;

    ptr_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .dir_we    (dir_we),
        .dir_sel   (dir_sel),
        .dir_wdata (dir_wdata),
        .iw_we     (iw_we),
        .iw_sel    (tgt_half),
        .iw_wdata  (ind_wdata),
        .up_en     (up_en),
        .up_idx    (src_vop.idx),
        .up_val    (calc.next),
        .ptrs      (ptrs)
    );

    always_comb begin
        dir_rdata = '0;
        if (dir_sel.hit) begin
            if (dir_sel.hi) dir_rdata = DW'({{(2*DW-AW){1'b0}}, ptrs[dir_sel.idx][AW-1:DW]});
            else            dir_rdata = ptrs[dir_sel.idx][DW-1:0];
        end
    end

    assign dir_to_sel = dir_we && dir_sel.hit && (dir_sel.idx == src_vop.idx);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ptrs == '0)); // R1

    AST_HI_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dir_sel.hit && dir_sel.hi) |-> (dir_rdata[DW-1:HIW] == '0)); // R2

    AST_FOREIGN_PASS: assert property (@(posedge clk) disable iff (rst)
        (ind_req && !src_vop.hit) |-> (eff_addr == ind_op && !suppress && !rd_zero)); // R3

    AST_PLAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (active && src_vop.mode == MD_PLAIN && !dir_to_sel && !iw_we)
        |=> (ptrs[$past(src_vop.idx)] == $past(sel_ptr))); // R4

    AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && src_vop.mode == MD_POSTINC && !dir_to_sel && !iw_we)
        |=> (ptrs[$past(src_vop.idx)] == $past(sel_ptr) + AW'(1))); // R5

    AST_ZERO_IN_VIRT: assert property (@(posedge clk) disable iff (rst)
        rd_zero |-> (int'(eff_addr) >= int'(VIRT_BASE) && int'(eff_addr) < VIRT_END
                     && suppress)); // R8

    AST_DIR_WINS: assert property (@(posedge clk) disable iff (rst)
        (dir_we && dir_sel.hit && !dir_sel.hi)
        |=> (ptrs[$past(dir_sel.idx)][DW-1:0] == $past(dir_wdata))); // R10
endmodule

// File: tb/ptr_file_test.sv
module ptr_file_test;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir_we = 1'b0;
    logic [11:0] dir_addr = 12'h000;
    logic [7:0]  dir_wdata = 8'h00;
    logic [7:0]  dir_rdata;
    logic        ind_req = 1'b0;
    logic        ind_wr = 1'b0;
    logic [11:0] ind_op = 12'h000;
    logic [7:0]  ind_wdata = 8'h00;
    logic [7:0]  wreg = 8'h00;
    logic [11:0] eff_addr;
    logic        suppress;
    logic        rd_zero;

    int    checks = 0;
    int    errors = 0;
    int    p[3];
    string dtag = "";

    always #(PER/2) clk = ~clk;

    ptr_file uut (
        .clk(clk), .rst(rst),
        .dir_we(dir_we), .dir_addr(dir_addr), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
        .ind_req(ind_req), .ind_wr(ind_wr), .ind_op(ind_op), .ind_wdata(ind_wdata),
        .wreg(wreg), .eff_addr(eff_addr), .suppress(suppress), .rd_zero(rd_zero)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit is_virt(input int a);
        for (int n = 0; n < 3; n++)
            for (int m = 0; m < 5; m++)
                if (a == 'hFE0 + 8*n + m) return 1;
        return 0;
    endfunction

    // one clock: evaluate model, compare, commit at the edge
    task automatic cyc();
        int pn[3];
        int hn, hm, pv, nv, a, w, e_eff, e_rd, tn;
        bit upd, iw, thi, th, e_sup, e_rz;
        string tg;
        #1;
        for (int n = 0; n < 3; n++) pn[n] = p[n];
        e_rd = 0;
        for (int n = 0; n < 3; n++) begin
            if (int'(dir_addr) == 'hFD8 + 2*n) e_rd = p[n] & 'hFF;
            if (int'(dir_addr) == 'hFD9 + 2*n) e_rd = p[n] >> 8;
        end
        hn = -1; hm = 0;
        for (int n = 0; n < 3; n++)
            for (int m = 0; m < 5; m++)
                if (int'(ind_op) == 'hFE0 + 8*n + m) begin hn = n; hm = m; end
        e_eff = int'(ind_op); e_sup = 0; e_rz = 0; tg = "R3"; upd = 0; iw = 0;
        if (ind_req && hn >= 0) begin
            pv = p[hn]; nv = pv; a = pv;
            case (hm)
                0: tg = "R4";
                1: begin nv = (pv - 1) & 'hFFF; upd = 1; tg = "R5"; end
                2: begin nv = (pv + 1) & 'hFFF; upd = 1; tg = "R5"; end
                3: begin nv = (pv + 1) & 'hFFF; a = nv; upd = 1; tg = "R6"; end
                default: begin
                    w = int'(wreg); if (w >= 128) w -= 256;
                    a = (pv + w) & 'hFFF; tg = "R7";
                end
            endcase
            th = 0; tn = 0; thi = 0;
            for (int n = 0; n < 3; n++) begin
                if (a == 'hFD8 + 2*n) begin th = 1; tn = n; thi = 0; end
                if (a == 'hFD9 + 2*n) begin th = 1; tn = n; thi = 1; end
            end
            if (is_virt(a)) begin
                e_sup = 1; e_rz = !ind_wr; tg = "R8";
            end else if (th && ind_wr) begin
                e_sup = 1; iw = 1; tg = "R9";
            end
            e_eff = a;
            if (upd && !iw) pn[hn] = nv;
            if (iw) begin
                if (thi) pn[tn] = (p[tn] & 'hFF) | ((int'(ind_wdata) & 'hF) << 8);
                else     pn[tn] = (p[tn] & 'hF00) | int'(ind_wdata);
            end
        end
        if (dir_we) begin
            for (int n = 0; n < 3; n++) begin
                if (int'(dir_addr) == 'hFD8 + 2*n) pn[n] = (p[n] & 'hF00) | int'(dir_wdata);
                if (int'(dir_addr) == 'hFD9 + 2*n) pn[n] = (p[n] & 'hFF) | ((int'(dir_wdata) & 'hF) << 8);
            end
        end
        chk(tg, "eff_addr", 32'(eff_addr), 32'(e_eff));
        chk(tg, "suppress", 32'(suppress), 32'(e_sup));
        chk(tg, "rd_zero", 32'(rd_zero), 32'(e_rz));
        chk((dtag != "") ? dtag : "R2", "dir_rdata", 32'(dir_rdata), 32'(e_rd));
        @(posedge clk);
        for (int n = 0; n < 3; n++) p[n] = pn[n];
        @(negedge clk);
    endtask

    task automatic idle();
        dir_we = 0; ind_req = 0; ind_wr = 0;
    endtask

    task automatic set_ptr(input int n, input int v);
        idle();
        dir_we = 1; dir_addr = 12'('hFD8 + 2*n); dir_wdata = 8'(v & 'hFF); cyc();
        dir_we = 1; dir_addr = 12'('hFD9 + 2*n); dir_wdata = 8'(v >> 8);   cyc();
        dir_we = 0;
    endtask

    task automatic ind(input int n, input int m, input bit wr, input int wd, input int w);
        ind_req = 1; ind_wr = wr; ind_op = 12'('hFE0 + 8*n + m);
        ind_wdata = 8'(wd); wreg = 8'(w);
        cyc();
        ind_req = 0; ind_wr = 0;
    endtask

    task automatic peek(input int n, input bit hi, input string tag);
        idle(); dtag = tag;
        dir_addr = 12'('hFD8 + 2*n + (hi ? 1 : 0));
        cyc();
        dtag = "";
    endtask

    initial begin
        #(PER*200000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < 3; n++) p[n] = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: all halves zero after reset
        for (int n = 0; n < 3; n++) begin
            peek(n, 0, "R1");
            peek(n, 1, "R1");
        end

        // R2: direct writes, high byte keeps only 4 bits
        set_ptr(0, 'h0FF);
        peek(0, 0, "R2"); peek(0, 1, "R2");
        idle(); dir_we = 1; dir_addr = 12'hFD9; dir_wdata = 8'hAB; cyc();
        peek(0, 1, "R2");
        idle(); dir_addr = 12'h123; cyc();   // R2: unmapped reads 00h

        // R5: carry and borrow across the byte boundary
        set_ptr(0, 'h0FF);
        ind(0, 2, 0, 0, 0); peek(0, 1, "R5"); peek(0, 0, "R5");
        set_ptr(1, 'h100);
        ind(1, 1, 0, 0, 0); peek(1, 1, "R5"); peek(1, 0, "R5");

        // R6: pre-increment wraps FFFh to 000h
        set_ptr(2, 'hFFF);
        ind(2, 3, 0, 0, 0); peek(2, 1, "R6"); peek(2, 0, "R6");
        set_ptr(2, 'hFFF);
        ind(2, 2, 0, 0, 0); peek(2, 0, "R5");

        // R7: sign-extended offsets
        set_ptr(2, 'h010);
        ind(2, 4, 0, 0, 'h80);
        ind(2, 4, 0, 0, 'h7F);
        ind(2, 4, 0, 0, 'hFF);
        peek(2, 0, "R7");

        // R4: plain leaves pointer
        ind(2, 0, 0, 0, 0); peek(2, 0, "R4");

        // R8: pointer aimed at a virtual code
        set_ptr(0, 'hFE8);
        ind(0, 0, 0, 0, 0);
        ind(0, 0, 1, 'h55, 0);
        ind(0, 2, 1, 'h55, 0); peek(0, 0, "R8");
        peek(1, 0, "R8");

        // R9: indirect write through post-increment onto pointer 0 high half
        set_ptr(1, 'hFD9);
        set_ptr(0, 'h234);
        ind(1, 2, 1, 'h35, 0);
        peek(0, 1, "R9"); peek(1, 0, "R9");
        // R9: read of a pointer half is a normal access
        ind(1, 0, 0, 0, 0);

        // R10: direct write beats auto-increment on the same pointer
        set_ptr(2, 'h1F0);
        dir_we = 1; dir_addr = 12'hFDC; dir_wdata = 8'h44;
        ind_req = 1; ind_wr = 0; ind_op = 12'hFF2;
        cyc();
        idle();
        peek(2, 0, "R10"); peek(2, 1, "R10");

        // R3: foreign operand with a request, and a virtual code without one
        ind_req = 1; ind_op = 12'h123; cyc();
        ind_req = 0; ind_op = 12'hFE2; cyc();
        idle();

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 7));
            dir_we = (r == 0);
            dir_addr = 12'('hFD6 + int'($urandom_range(0, 9)));
            case ($urandom_range(0, 5))
                0: dir_wdata = 8'(8'hE0 + 8'($urandom_range(0, 12)));
                1: dir_wdata = 8'(8'hD8 + 8'($urandom_range(0, 5)));
                2: dir_wdata = 8'hFF;
                3: dir_wdata = 8'h00;
                4: dir_wdata = 8'h0F;
                default: dir_wdata = 8'($urandom);
            endcase
            ind_req = ($urandom_range(0, 3) != 0);
            ind_wr  = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 9) == 0) ind_op = 12'($urandom);
            else ind_op = 12'('hFE0 + 8*int'($urandom_range(0, 2)) + int'($urandom_range(0, 4)));
            ind_wdata = 8'($urandom);
            wreg = 8'($urandom);
            cyc();
        end
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule